// File: doc/BRIEF.md
# SCSI Initiator Manual Byte Handshake Unit

This block moves one byte across a SCSI bus for the initiator each time the host touches its transfer data port. Before it moves anything it makes two checks against the registered bus image, the sense register. First, the target must be raising both REQ and BSY. Second, the phase the host expects, held in a small phase-control register, must equal the phase the bus is showing. A refused read returns a filler byte. A phase disagreement seen during an active transfer raises a service-required interrupt flag.

When both checks pass, the current bus phase decides where the byte goes. Data phases use an external byte buffer through an auto-incrementing pointer. Command bytes are written into a CDB store, and the opcode's group decides how long the command is. Status and message-in bytes come from the target. Message-out bytes go to the target, and any flag the target returns is folded into a pending message-in indicator.

After a byte is moved, the sense register shows ACK with BSY and the phase. That image, and the ACK output, are held until the target drops REQ.

Top module: `scsi_hs_unit`

## Requirements
- R1: An access is refused with no byte moved unless sense bit 7 (REQ) and sense bit 5 (BSY) are both 1. A refused read returns 8'hFF when sense bit 0 (I/O) is 1 and 8'h00 when it is 0.
- R2: An access is refused with no byte moved unless the phase-control value equals sense bits [2:0]. These bits are {MSG, C/D, I/O}, with the codes data-out 000, data-in 001, command 010, status 011, message-out 110 and message-in 111.
- R3: A phase disagreement raises `int_svc_o` only when REQ and BSY pass and `xfer_active_i` is 1. The flag stays set until a pulse on `svc_clr_i`.
- R4: A data-in read returns `buf_rdata_i` at `buf_addr_o` and then advances the pointer. A data-out write drives `buf_we_o` with the host byte at the pointer and then advances it. While `xfer_active_i` is 0 the pointer is 0.
- R5: The first command byte sets `cdb_len_o` from opcode bits [7:5]: group 0 gives 6, groups 1 and 2 give 10, group 5 gives 12, and any other group gives 6. Bytes are stored at CDB index 0, 1, 2 and so on. `cmd_done_o` pulses for one cycle after the last byte, and `xfer_active_i` at 0 clears the tracking.
- R6: A status read returns `tgt_status_i`. A message-in read returns `tgt_min_i`, pulses `tgt_min_take_o` and clears `msgin_pend_o`.
- R7: A message-out write drives `tgt_mout_we_o` with the host byte. A 1 on `tgt_mout_flag_i` in that cycle sets `msgin_pend_o`, which a later 0 flag does not clear.
- R8: After a moved byte, `ack_o` is 1 and `sense_o` is 8'h60 OR the phase code: bit 6 is ACK, bit 5 is BSY, and bit 7 (REQ) is 0.
- R9: `ack_o` and `sense_o` hold while `bus_req_i` stays 1, so further accesses are refused. On the first cycle with `bus_req_i` at 0, `ack_o` clears and `sense_o` samples the bus again.
- R10: A read in an output phase, a write in an input phase, and any access under codes 100 or 101 are refused with no byte moved.
- R11: After reset, `sense_o`, `ack_o`, `int_svc_o`, `msgin_pend_o`, `host_rvalid_o` and `cmd_done_o` are 0, and the phase-control value is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_rd_i | input | 1 | Host read of transfer port |
| host_wr_i | input | 1 | Host write of transfer port |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Read result |
| host_rvalid_o | output | 1 | Read result valid |
| pctl_we_i | input | 1 | Phase-control write |
| pctl_wdata_i | input | 3 | Expected phase code |
| bus_req_i | input | 1 | Bus REQ |
| bus_bsy_i | input | 1 | Bus BSY |
| bus_phase_i | input | 3 | Bus {MSG, C/D, I/O} |
| sense_o | output | 8 | Sense register image |
| ack_o | output | 1 | ACK to bus |
| xfer_active_i | input | 1 | Transfer command active |
| svc_clr_i | input | 1 | Clear service-required flag |
| int_svc_o | output | 1 | Service-required flag |
| buf_addr_o | output | ADDR_W | Buffer pointer |
| buf_rdata_i | input | 8 | Buffer read byte |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write byte |
| cdb_we_o | output | 1 | CDB store strobe |
| cdb_idx_o | output | 4 | CDB byte index |
| cdb_byte_o | output | 8 | CDB byte |
| cdb_len_o | output | 4 | Command length |
| cmd_done_o | output | 1 | Command-complete pulse |
| tgt_status_i | input | 8 | Target status byte |
| tgt_min_i | input | 8 | Target message-in byte |
| tgt_min_take_o | output | 1 | Message-in byte consumed |
| tgt_mout_we_o | output | 1 | Message-out strobe |
| tgt_mout_byte_o | output | 8 | Message-out byte |
| tgt_mout_flag_i | input | 1 | Target wants message-in |
| msgin_pend_o | output | 1 | Pending message-in |

## Verification
The buffer, CDB, message-out and message-in strobes are combinational. They are due in the same cycle as the access, so the bench model captures them on the edge that ends that access. The read byte, `host_rvalid_o`, `sense_o`, `ack_o`, `cdb_len_o`, `cmd_done_o`, `int_svc_o` and `msgin_pend_o` change on the edge that ends the access. Every task therefore drives its access for one cycle after a falling edge and checks these outputs at the next falling edge. Bus line changes reach `sense_o` one edge later, so each bus update waits one full cycle before the access that depends on it.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;

    localparam int SN_REQ    = 7;
    localparam int SN_ACK    = 6;
    localparam int SN_BSY    = 5;
    localparam int CDB_MAX   = 12;
    localparam int CDB_IDX_W = $clog2(CDB_MAX + 1);

    typedef enum logic [2:0] {
        PH_DOUT = 3'b000,
        PH_DIN  = 3'b001,
        PH_CMD  = 3'b010,
        PH_STAT = 3'b011,
        PH_RSV0 = 3'b100,
        PH_RSV1 = 3'b101,
        PH_MOUT = 3'b110,
        PH_MIN  = 3'b111
    } phase_e;

    typedef enum logic [1:0] {
        GV_GO,
        GV_NOREADY,
        GV_MISMATCH,
        GV_REFUSE
    } verdict_e;

    // Command length from opcode group (bits 7:5)
    function automatic logic [CDB_IDX_W-1:0] cdb_len_of(input logic [7:0] op);
        case (op[7:5])
            3'd1, 3'd2: cdb_len_of = CDB_IDX_W'(10);
            3'd5:       cdb_len_of = CDB_IDX_W'(12);
            default:    cdb_len_of = CDB_IDX_W'(6);
        endcase
    endfunction

endpackage

// File: rtl/scsi_hs_gate.sv
module scsi_hs_gate
    import scsi_hs_pkg::*;
(
    input  logic     rd_i,
    input  logic     wr_i,
    input  logic     req_i,
    input  logic     bsy_i,
    input  logic [2:0] phase_i,
    input  logic [2:0] pctl_i,
    output verdict_e verdict_o,
    output logic     go_o
);

    phase_e ph;
    logic   dir_ok;

    always_comb begin
        ph = phase_e'(phase_i);
        case (ph)
            PH_DIN, PH_STAT, PH_MIN:  dir_ok = rd_i;
            PH_DOUT, PH_CMD, PH_MOUT: dir_ok = wr_i && !rd_i;
            default:                  dir_ok = 1'b0;
        endcase

        if (!(req_i && bsy_i)) begin
            verdict_o = GV_NOREADY;
        end else if (pctl_i != phase_i) begin
            verdict_o = GV_MISMATCH;
        end else if (!dir_ok) begin
            verdict_o = GV_REFUSE;
        end else begin
            verdict_o = GV_GO;
        end

        go_o = (rd_i || wr_i) && (verdict_o == GV_GO);
    end

endmodule

// File: rtl/scsi_hs_sense.sv
module scsi_hs_sense
    import scsi_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req_i,
    input  logic       bus_bsy_i,
    input  logic [2:0] bus_phase_i,
    input  logic       moved_i,
    output logic [7:0] sense_o,
    output logic       ack_o
);

    typedef struct packed {
        logic [7:0] sense;
        logic       ack;
    } sense_st_t;

    sense_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (moved_i) begin
            st_d.ack              = 1'b1;
            st_d.sense            = 8'h00;
            st_d.sense[SN_ACK]    = 1'b1;
            st_d.sense[SN_BSY]    = 1'b1;
            st_d.sense[2:0]       = st_q.sense[2:0];
        end else if (!st_q.ack || !bus_req_i) begin
            st_d.ack              = 1'b0;
            st_d.sense            = 8'h00;
            st_d.sense[SN_REQ]    = bus_req_i;
            st_d.sense[SN_BSY]    = bus_bsy_i;
            st_d.sense[2:0]       = bus_phase_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sense_o = st_q.sense;
    assign ack_o   = st_q.ack;

endmodule

// File: rtl/scsi_hs_cdb.sv
module scsi_hs_cdb
    import scsi_hs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 strobe_i,
    input  logic [7:0]           byte_i,
    output logic                 cdb_we_o,
    output logic [CDB_IDX_W-1:0] cdb_idx_o,
    output logic [CDB_IDX_W-1:0] len_o,
    output logic                 done_o
);

    typedef struct packed {
        logic                 busy;
        logic [CDB_IDX_W-1:0] idx;
        logic [CDB_IDX_W-1:0] remain;
        logic [CDB_IDX_W-1:0] len;
        logic                 done;
    } cdb_st_t;

    cdb_st_t              st_d, st_q;
    logic [CDB_IDX_W-1:0] first_len;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        first_len = cdb_len_of(byte_i);
        cdb_we_o  = strobe_i && en_i;
        cdb_idx_o = st_q.busy ? st_q.idx : '0;

        if (!en_i) begin
            st_d.busy   = 1'b0;
            st_d.idx    = '0;
            st_d.remain = '0;
        end else if (strobe_i) begin
            if (!st_q.busy) begin
                st_d.len    = first_len;
                st_d.remain = first_len - CDB_IDX_W'(1);
                st_d.idx    = CDB_IDX_W'(1);
                st_d.busy   = (first_len != CDB_IDX_W'(1));
                st_d.done   = (first_len == CDB_IDX_W'(1));
            end else begin
                st_d.remain = st_q.remain - CDB_IDX_W'(1);
                st_d.idx    = st_q.idx + CDB_IDX_W'(1);
                if (st_q.remain == CDB_IDX_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.idx  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o  = st_q.len;
    assign done_o = st_q.done;

endmodule

// File: rtl/scsi_hs_unit.sv
module scsi_hs_unit
    import scsi_hs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_rd_i,
    input  logic                 host_wr_i,
    input  logic [7:0]           host_wdata_i,
    output logic [7:0]           host_rdata_o,
    output logic                 host_rvalid_o,
    input  logic                 pctl_we_i,
    input  logic [2:0]           pctl_wdata_i,
    input  logic                 bus_req_i,
    input  logic                 bus_bsy_i,
    input  logic [2:0]           bus_phase_i,
    output logic [7:0]           sense_o,
    output logic                 ack_o,
    input  logic                 xfer_active_i,
    input  logic                 svc_clr_i,
    output logic                 int_svc_o,
    output logic [ADDR_W-1:0]    buf_addr_o,
    input  logic [7:0]           buf_rdata_i,
    output logic                 buf_we_o,
    output logic [7:0]           buf_wdata_o,
    output logic                 cdb_we_o,
    output logic [CDB_IDX_W-1:0] cdb_idx_o,
    output logic [7:0]           cdb_byte_o,
    output logic [CDB_IDX_W-1:0] cdb_len_o,
    output logic                 cmd_done_o,
    input  logic [7:0]           tgt_status_i,
    input  logic [7:0]           tgt_min_i,
    output logic                 tgt_min_take_o,
    output logic                 tgt_mout_we_o,
    output logic [7:0]           tgt_mout_byte_o,
    input  logic                 tgt_mout_flag_i,
    output logic                 msgin_pend_o
);

    localparam logic [7:0] FILL_IN  = 8'hFF;
    localparam logic [7:0] FILL_OUT = 8'h00;

    typedef struct packed {
        logic [2:0]        pctl;
        logic [ADDR_W-1:0] ptr;
        logic [7:0]        rdata;
        logic              rvalid;
        logic              svc;
        logic              pend;
    } unit_st_t;

    unit_st_t st_d, st_q;
    verdict_e verdict;
    logic     go;
    logic     access;
    phase_e   cur_ph;
    logic     moved;

    scsi_hs_gate u_gate (
        .rd_i      (host_rd_i),
        .wr_i      (host_wr_i),
        .req_i     (sense_o[SN_REQ]),
        .bsy_i     (sense_o[SN_BSY]),
        .phase_i   (sense_o[2:0]),
        .pctl_i    (st_q.pctl),
        .verdict_o (verdict),
        .go_o      (go)
    );

    scsi_hs_sense u_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req_i   (bus_req_i),
        .bus_bsy_i   (bus_bsy_i),
        .bus_phase_i (bus_phase_i),
        .moved_i     (moved),
        .sense_o     (sense_o),
        .ack_o       (ack_o)
    );

    scsi_hs_cdb u_cdb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (xfer_active_i),
        .strobe_i  (go && (cur_ph == PH_CMD)),
        .byte_i    (host_wdata_i),
        .cdb_we_o  (cdb_we_o),
        .cdb_idx_o (cdb_idx_o),
        .len_o     (cdb_len_o),
        .done_o    (cmd_done_o)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        access      = host_rd_i || host_wr_i;
        cur_ph      = phase_e'(sense_o[2:0]);
        moved       = go;

        if (pctl_we_i) begin
            st_d.pctl = pctl_wdata_i;
        end

        if (svc_clr_i) begin
            st_d.svc = 1'b0;
        end
        if (access && (verdict == GV_MISMATCH) && xfer_active_i) begin
            st_d.svc = 1'b1;
        end

        if (host_rd_i) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = sense_o[0] ? FILL_IN : FILL_OUT;
            if (go) begin
                case (cur_ph)
                    PH_DIN:  st_d.rdata = buf_rdata_i;
                    PH_STAT: st_d.rdata = tgt_status_i;
                    PH_MIN:  st_d.rdata = tgt_min_i;
                    default: st_d.rdata = st_d.rdata;
                endcase
            end
        end

        if (go && ((cur_ph == PH_DIN) || (cur_ph == PH_DOUT))) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
        end
        if (!xfer_active_i) begin
            st_d.ptr = '0;
        end

        if (go && (cur_ph == PH_MOUT) && tgt_mout_flag_i) begin
            st_d.pend = 1'b1;
        end
        if (go && (cur_ph == PH_MIN)) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata_o    = st_q.rdata;
    assign host_rvalid_o   = st_q.rvalid;
    assign int_svc_o       = st_q.svc;
    assign msgin_pend_o    = st_q.pend;
    assign buf_addr_o      = st_q.ptr;
    assign buf_we_o        = go && (cur_ph == PH_DOUT);
    assign buf_wdata_o     = host_wdata_i;
    assign cdb_byte_o      = host_wdata_i;
    assign tgt_mout_we_o   = go && (cur_ph == PH_MOUT);
    assign tgt_mout_byte_o = host_wdata_i;
    assign tgt_min_take_o  = go && (cur_ph == PH_MIN);

endmodule

// File: rtl/scsi_hs_checker.sv
module scsi_hs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rd,
    input logic       host_wr,
    input logic [2:0] pctl,
    input logic       bus_req,
    input logic [7:0] sense,
    input logic       ack,
    input logic       xfer_active,
    input logic       svc,
    input logic       buf_we,
    input logic       cdb_we,
    input logic       mout_we,
    input logic       min_take,
    input logic       cmd_done
);

    logic moved;
    assign moved = buf_we || cdb_we || mout_we || min_take;

    // R1
    a_r1_ready_before_move: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> (sense[7] && sense[5]));

    // R2
    a_r2_phase_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> (sense[2:0] == pctl));

    // R3
    a_r3_svc_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && sense[7] && sense[5] && (sense[2:0] != pctl) && xfer_active)
        |=> svc);

    // R8
    a_r8_ack_after_move: assert property (@(posedge clk) disable iff (!rst_n)
        moved |=> (ack && sense[6] && sense[5] && !sense[7]));

    // R9
    a_r9_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && bus_req) |=> (ack && $stable(sense)));

    // R5
    a_r5_done_after_cdb: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(cdb_we));

endmodule

bind scsi_hs_unit scsi_hs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd     (host_rd_i),
    .host_wr     (host_wr_i),
    .pctl        (st_q.pctl),
    .bus_req     (bus_req_i),
    .sense       (sense_o),
    .ack         (ack_o),
    .xfer_active (xfer_active_i),
    .svc         (int_svc_o),
    .buf_we      (buf_we_o),
    .cdb_we      (cdb_we_o),
    .mout_we     (tgt_mout_we_o),
    .min_take    (tgt_min_take_o),
    .cmd_done    (cmd_done_o)
);

// File: tb/scsi_hs_unit_bench.sv
module scsi_hs_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd = 0, host_wr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic       pctl_we = 0;
    logic [2:0] pctl_wdata = 0;
    logic       bus_req = 0, bus_bsy = 0;
    logic [2:0] bus_phase = 0;
    logic [7:0] sense;
    logic       ack;
    logic       xfer_active = 1;
    logic       svc_clr = 0;
    logic       int_svc;
    logic [3:0] buf_addr;
    logic [7:0] buf_rdata;
    logic       buf_we;
    logic [7:0] buf_wdata;
    logic       cdb_we;
    logic [3:0] cdb_idx;
    logic [7:0] cdb_byte;
    logic [3:0] cdb_len;
    logic       cmd_done;
    logic [7:0] tgt_status = 8'h02;
    logic [7:0] tgt_min = 8'h04;
    logic       min_take;
    logic       mout_we;
    logic [7:0] mout_byte;
    logic       mout_flag;
    logic       pend;

    logic [7:0] mem [16];
    logic [7:0] cdb_cap [16];
    logic [7:0] last_mout = 8'h00;
    int         n_chk = 0;
    int         n_err = 0;
    bit         finished = 0;

    always #2 clk = ~clk;

    assign buf_rdata = mem[buf_addr];
    assign mout_flag = mout_we && (mout_byte == 8'hC0);

    always @(posedge clk) begin
        if (buf_we) mem[buf_addr] <= buf_wdata;
        if (cdb_we) cdb_cap[cdb_idx] <= cdb_byte;
        if (mout_we) last_mout <= mout_byte;
    end

    scsi_hs_unit #(.ADDR_W(4)) u_scsi_hs_unit (
        .clk(clk), .rst_n(rst_n),
        .host_rd_i(host_rd), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
        .host_rdata_o(host_rdata), .host_rvalid_o(host_rvalid),
        .pctl_we_i(pctl_we), .pctl_wdata_i(pctl_wdata),
        .bus_req_i(bus_req), .bus_bsy_i(bus_bsy), .bus_phase_i(bus_phase),
        .sense_o(sense), .ack_o(ack),
        .xfer_active_i(xfer_active), .svc_clr_i(svc_clr), .int_svc_o(int_svc),
        .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata), .buf_we_o(buf_we),
        .buf_wdata_o(buf_wdata),
        .cdb_we_o(cdb_we), .cdb_idx_o(cdb_idx), .cdb_byte_o(cdb_byte),
        .cdb_len_o(cdb_len), .cmd_done_o(cmd_done),
        .tgt_status_i(tgt_status), .tgt_min_i(tgt_min), .tgt_min_take_o(min_take),
        .tgt_mout_we_o(mout_we), .tgt_mout_byte_o(mout_byte),
        .tgt_mout_flag_i(mout_flag), .msgin_pend_o(pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks begin and end just after a falling edge
    task automatic set_bus(input logic r, input logic b, input logic [2:0] ph);
        bus_req = r; bus_bsy = b; bus_phase = ph;
        @(negedge clk);
    endtask

    task automatic set_pctl(input logic [2:0] p);
        pctl_we = 1; pctl_wdata = p;
        @(negedge clk);
        pctl_we = 0;
    endtask

    task automatic zero_ptr();
        xfer_active = 0;
        @(negedge clk);
        xfer_active = 1;
    endtask

    task automatic hwrite(input logic [7:0] b);
        host_wr = 1; host_wdata = b;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(output logic [7:0] b);
        host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        b = host_rdata;
    endtask

    task automatic release_ack();
        bus_req = 0;
        @(negedge clk);
        bus_req = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 sense", sense, 8'h00);
        chk("R11 ack", ack, 0);
        chk("R11 svc", int_svc, 0);
        chk("R11 pend", pend, 0);
        chk("R11 rvalid", host_rvalid, 0);
        chk("R11 done", cmd_done, 0);
    endtask

    task automatic t_data_out();
        zero_ptr();
        set_pctl(3'b000);
        set_bus(1, 1, 3'b000);
        hwrite(8'hA5);
        chk("R4 dout byte0", mem[0], 8'hA5);
        chk("R8 dout sense", sense, 8'h60);
        chk("R8 dout ack", ack, 1);
        release_ack();
        hwrite(8'h5A);
        chk("R4 dout byte1", mem[1], 8'h5A);
        release_ack();
    endtask

    task automatic t_data_in();
        logic [7:0] v;
        mem[0] = 8'h3C; mem[1] = 8'hC3;
        zero_ptr();
        set_pctl(3'b001);
        set_bus(1, 1, 3'b001);
        hread(v);
        chk("R4 din byte0", v, 8'h3C);
        chk("R4 din rvalid", host_rvalid, 1);
        chk("R8 din sense", sense, 8'h61);
        release_ack();
        hread(v);
        chk("R4 din byte1", v, 8'hC3);
        release_ack();
    endtask

    task automatic t_not_ready();
        logic [7:0] v;
        zero_ptr();
        set_pctl(3'b001);
        set_bus(0, 1, 3'b001);
        hread(v);
        chk("R1 no REQ fill", v, 8'hFF);
        chk("R1 no REQ ack", ack, 0);
        chk("R3 no svc on not ready", int_svc, 0);
        set_bus(1, 0, 3'b001);
        hread(v);
        chk("R1 no BSY fill", v, 8'hFF);
        set_bus(1, 1, 3'b001);
        hread(v);
        chk("R1 pointer kept", v, 8'h3C);
        release_ack();
        mem[1] = 8'hC3;
        set_pctl(3'b000);
        set_bus(0, 1, 3'b000);
        hwrite(8'h77);
        chk("R1 write refused mem", mem[1], 8'hC3);
        chk("R1 write refused ack", ack, 0);
    endtask

    task automatic t_mismatch();
        logic [7:0] v;
        set_pctl(3'b000);
        set_bus(1, 1, 3'b001);
        hread(v);
        chk("R2 mismatch fill", v, 8'hFF);
        chk("R2 mismatch ack", ack, 0);
        chk("R3 svc set", int_svc, 1);
        svc_clr = 1;
        @(negedge clk);
        svc_clr = 0;
        chk("R3 svc cleared", int_svc, 0);
        xfer_active = 0;
        hread(v);
        chk("R3 no svc when idle", int_svc, 0);
        xfer_active = 1;
        @(negedge clk);
    endtask

    task automatic t_direction();
        logic [7:0] v;
        set_pctl(3'b000);
        set_bus(1, 1, 3'b000);
        hread(v);
        chk("R10 read in out phase", v, 8'h00);
        chk("R10 read in out phase ack", ack, 0);
        set_pctl(3'b101);
        set_bus(1, 1, 3'b101);
        hread(v);
        chk("R10 reserved code fill", v, 8'hFF);
        chk("R10 reserved code ack", ack, 0);
        set_pctl(3'b001);
        set_bus(1, 1, 3'b001);
        mem[0] = 8'h99;
        zero_ptr();
        hwrite(8'h11);
        chk("R10 write in in phase ack", ack, 0);
    endtask

    task automatic t_command();
        zero_ptr();
        set_pctl(3'b010);
        set_bus(1, 1, 3'b010);
        hwrite(8'h28);
        chk("R5 len group1", cdb_len, 4'd10);
        chk("R8 cmd sense", sense, 8'h62);
        for (int i = 1; i < 10; i++) begin
            release_ack();
            hwrite(8'(i));
            if (i == 8) chk("R5 no early done", cmd_done, 0);
        end
        chk("R5 done pulse", cmd_done, 1);
        chk("R5 cdb first", cdb_cap[0], 8'h28);
        chk("R5 cdb last", cdb_cap[9], 8'h09);
        release_ack();
        chk("R5 done one cycle", cmd_done, 0);
        zero_ptr();
        hwrite(8'hA8);
        chk("R5 len group5", cdb_len, 4'd12);
        release_ack();
        zero_ptr();
        hwrite(8'h12);
        chk("R5 len group0", cdb_len, 4'd6);
        release_ack();
        zero_ptr();
        hwrite(8'h60);
        chk("R5 len group3 default", cdb_len, 4'd6);
        release_ack();
        zero_ptr();
    endtask

    task automatic t_status_msg();
        logic [7:0] v;
        set_pctl(3'b011);
        set_bus(1, 1, 3'b011);
        hread(v);
        chk("R6 status byte", v, 8'h02);
        chk("R8 status sense", sense, 8'h63);
        release_ack();
        set_pctl(3'b110);
        set_bus(1, 1, 3'b110);
        hwrite(8'h80);
        chk("R7 mout byte", last_mout, 8'h80);
        chk("R7 no pend", pend, 0);
        release_ack();
        hwrite(8'hC0);
        chk("R7 pend set", pend, 1);
        release_ack();
        hwrite(8'h80);
        chk("R7 pend sticky", pend, 1);
        release_ack();
        set_pctl(3'b111);
        set_bus(1, 1, 3'b111);
        hread(v);
        chk("R6 msg in byte", v, 8'h04);
        chk("R6 pend cleared", pend, 0);
        chk("R8 msg in sense", sense, 8'h67);
        release_ack();
    endtask

    task automatic t_hold();
        zero_ptr();
        set_pctl(3'b000);
        set_bus(1, 1, 3'b000);
        mem[1] = 8'hEE;
        hwrite(8'h11);
        repeat (3) begin
            @(negedge clk);
            chk("R9 ack held", ack, 1);
        end
        hwrite(8'h22);
        chk("R9 second write refused", mem[1], 8'hEE);
        chk("R9 sense held", sense, 8'h60);
        bus_req = 0;
        @(negedge clk);
        chk("R9 ack released", ack, 0);
        chk("R9 sense resampled", sense, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_data_out();
        t_data_in();
        t_not_ready();
        t_mismatch();
        t_direction();
        t_command();
        t_status_msg();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule